// File: doc/BRIEF.md
# Packed Fused Multiply Alternating Add/Subtract Lane Sequencer

This block runs one packed fused multiply with alternating subtract and add across up to eight 64-bit lanes. It captures three 512-bit operand vectors (the destination's old value and two sources) on a start pulse. It also captures the operand-order form, the vector length, the write-mask controls, the memory-source and broadcast flags and two rounding-control fields. It then hands the active lanes, one at a time, to a single external fused multiply-add unit that always computes `a*b+c`.

Each request carries two multiplicands, an addend and a two-bit rounding mode. On even lanes the addend's sign bit is inverted, so those lanes compute product minus addend. Odd lanes compute product plus addend. Each returned result is written into its lane of a destination register. Inactive lanes are filled by merge or zero masking. Lanes beyond the vector length are cleared. A one-cycle `done` pulse marks the cycle in which `dest_out` holds the finished vector.

Top module: `fmas_lane_seq`

## Requirements
- R1: After synchronous reset, `done` and `fma_valid` are 0 and `dest_out` is all zero.
- R2: `vlen_sel` 0, 1 and 2 give 2, 4 and 8 lanes; code 3 also gives 8 lanes. Lane j occupies bits [64j+63:64j]. Every `dest_out` bit of a lane at or above the lane count is 0 when `done` is high.
- R3: On an even lane index, `fma_c` is the selected addend with bit 63 inverted. On an odd index, it is the addend unchanged.
- R4: `form_sel` 0 (and the spare code 3) sends a=DEST, b=SRC3, c=SRC2. Code 1 sends a=SRC2, b=DEST, c=SRC3. Code 2 sends a=SRC2, b=SRC3, c=DEST. The vectors are `dest_in`, `src2_in` and `src3_in`.
- R5: With `mask_en`=0 every lane below the length is active. With `mask_en`=1, lane j is active only when `mask_bits[j]` is 1. An inactive lane within the length keeps its DEST value when `zero_mode`=0 and becomes 0 when `zero_mode`=1.
- R6: When `mem_src`=1 and `bcast`=1, every lane uses SRC3 bits [63:0] in place of its own SRC3 element. Otherwise each lane uses its own element.
- R7: `fma_rm` equals `rc_embed` when `mem_src`=0, `bcast`=1 and `vlen_sel` is 2 or 3. In all other cases it equals `rc_global`.
- R8: Active lanes are requested in ascending index order, and inactive lanes make no request. A request holds `fma_valid` and its operands steady until `fma_ready`. No new request starts until `res_valid` returns the result.
- R9: Each `res_data` is written into the lane that was last requested. `done` is high for exactly one cycle, in the cycle after the last result is captured, or in the cycle after start when no lane is active.
- R10: A `start` while an operation is in progress is ignored, and the operation completes with its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| form_sel | input | 2 | Operand-order form |
| vlen_sel | input | 2 | Vector length code |
| mask_en | input | 1 | Write masking enabled |
| mask_bits | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | 1 = zero inactive lanes, 0 = merge |
| mem_src | input | 1 | SRC3 comes from memory |
| bcast | input | 1 | Broadcast / embedded-rounding flag |
| rc_embed | input | 2 | Per-operation rounding mode |
| rc_global | input | 2 | Global rounding mode |
| dest_in | input | 512 | Old destination value |
| src2_in | input | 512 | Second source vector |
| src3_in | input | 512 | Third source vector |
| fma_valid | output | 1 | Request to the multiply-add unit |
| fma_ready | input | 1 | Multiply-add unit accepts request |
| fma_a | output | 64 | First multiplicand |
| fma_b | output | 64 | Second multiplicand |
| fma_c | output | 64 | Addend (sign-adjusted) |
| fma_rm | output | 2 | Rounding mode for the request |
| res_valid | input | 1 | Result returned |
| res_data | input | 64 | Result value |
| done | output | 1 | One-cycle pulse: dest_out valid |
| dest_out | output | 512 | Assembled destination vector |

## Verification
The hardest situation to reach from the ports is a second start arriving while lanes are still outstanding, together with a multiply-add unit that stalls its ready. If either goes wrong, the trace looks plausible but a lane is misrouted or its operands change. The stimulus pulses start again with different form, length and data one cycle after a genuine start. Meanwhile, a responder holds ready low for a configurable number of cycles and checks at each stalled cycle that the request stays put. A scoreboard compares every issued request, including its rounding mode, against requests predicted independently per lane.

// File: rtl/fmas_pkg.sv
package fmas_pkg;

    localparam int LANE_W    = 64;
    localparam int MAX_LANES = 8;
    localparam int RM_W      = 2;

    typedef enum logic [1:0] {
        FORM_132 = 2'd0,
        FORM_213 = 2'd1,
        FORM_231 = 2'd2,
        FORM_SPR = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    typedef struct packed {
        form_e             form;
        logic              bcast_src3;
        logic [RM_W-1:0]   rm;
    } op_ctl_t;

    // Number of lanes for a length code (3 aliases the widest length).
    function automatic logic [3:0] lanes_for_len(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/fmas_lane_enable.sv
module fmas_lane_enable
    import fmas_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  logic [1:0]       vlen_sel,
    input  logic             mask_en,
    input  logic [LANES-1:0] mask_bits,
    output logic [LANES-1:0] in_len,
    output logic [LANES-1:0] active
);
    logic [3:0] limit;
    assign limit = lanes_for_len(vlen_sel);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign in_len[j] = (4'(j) < limit);
        assign active[j] = in_len[j] & (~mask_en | mask_bits[j]);
    end
endmodule

// File: rtl/fmas_pick_lowest.sv
module fmas_pick_lowest #(
    parameter int N     = 8,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic [N-1:0]    grant,
    output logic [IDXW-1:0] idx,
    output logic            any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (req[j] && !any) begin
                any      = 1'b1;
                grant[j] = 1'b1;
                idx      = IDXW'(j);
            end
        end
    end
endmodule

// File: rtl/fmas_lane_mux.sv
module fmas_lane_mux
    import fmas_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  form_e        form,
    input  logic         use_bcast,
    input  logic         even_lane,
    input  logic [W-1:0] dest_l,
    input  logic [W-1:0] src2_l,
    input  logic [W-1:0] src3_l,
    input  logic [W-1:0] src3_low,
    output logic [W-1:0] mul_a,
    output logic [W-1:0] mul_b,
    output logic [W-1:0] addend
);
    logic [W-1:0] s3;
    logic [W-1:0] raw_c;

    assign s3 = use_bcast ? src3_low : src3_l;

    always_comb begin
        case (form)
            FORM_213: begin mul_a = src2_l; mul_b = dest_l; raw_c = s3;     end
            FORM_231: begin mul_a = src2_l; mul_b = s3;     raw_c = dest_l; end
            default:  begin mul_a = dest_l; mul_b = s3;     raw_c = src2_l; end
        endcase
    end

    // Even lanes subtract: flip the addend sign so the unit still does a*b+c.
    assign addend = {raw_c[W-1] ^ even_lane, raw_c[W-2:0]};
endmodule

// File: rtl/fmas_lane_seq.sv
module fmas_lane_seq
    import fmas_pkg::*;
#(
    parameter int LW    = LANE_W,
    parameter int LANES = MAX_LANES,
    localparam int VW   = LW * LANES,
    localparam int IDXW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       form_sel,
    input  logic [1:0]       vlen_sel,
    input  logic             mask_en,
    input  logic [LANES-1:0] mask_bits,
    input  logic             zero_mode,
    input  logic             mem_src,
    input  logic             bcast,
    input  logic [RM_W-1:0]  rc_embed,
    input  logic [RM_W-1:0]  rc_global,
    input  logic [VW-1:0]    dest_in,
    input  logic [VW-1:0]    src2_in,
    input  logic [VW-1:0]    src3_in,
    output logic             fma_valid,
    input  logic             fma_ready,
    output logic [LW-1:0]    fma_a,
    output logic [LW-1:0]    fma_b,
    output logic [LW-1:0]    fma_c,
    output logic [RM_W-1:0]  fma_rm,
    input  logic             res_valid,
    input  logic [LW-1:0]    res_data,
    output logic             done,
    output logic [VW-1:0]    dest_out
);
    state_e           state_q;
    op_ctl_t          ctl_q;
    logic [VW-1:0]    dest_q, src2_q, src3_q, res_q;
    logic [LANES-1:0] pending_q, in_len_q;

    logic [LANES-1:0] in_len_d, active_d, grant;
    logic [IDXW-1:0]  idx;
    logic             any_pending;
    logic [VW-1:0]    init_res;
    op_ctl_t          ctl_d;

    fmas_lane_enable #(.LANES(LANES)) u_enable (
        .vlen_sel  (vlen_sel),
        .mask_en   (mask_en),
        .mask_bits (mask_bits),
        .in_len    (in_len_d),
        .active    (active_d)
    );

    fmas_pick_lowest #(.N(LANES)) u_pick (
        .req   (pending_q),
        .grant (grant),
        .idx   (idx),
        .any   (any_pending)
    );

    fmas_lane_mux #(.W(LW)) u_mux (
        .form      (ctl_q.form),
        .use_bcast (ctl_q.bcast_src3),
        .even_lane (~idx[0]),
        .dest_l    (dest_q[idx*LW +: LW]),
        .src2_l    (src2_q[idx*LW +: LW]),
        .src3_l    (src3_q[idx*LW +: LW]),
        .src3_low  (src3_q[LW-1:0]),
        .mul_a     (fma_a),
        .mul_b     (fma_b),
        .addend    (fma_c)
    );

    // Starting destination: masked-off lanes inside the length merge or zero;
    // active lanes and lanes past the length start at zero.
    for (genvar j = 0; j < LANES; j++) begin : g_init
        assign init_res[j*LW +: LW] =
            (in_len_d[j] && !active_d[j] && !zero_mode) ? dest_in[j*LW +: LW] : '0;
    end

    always_comb begin
        ctl_d.form       = form_e'(form_sel);
        ctl_d.bcast_src3 = mem_src & bcast;
        ctl_d.rm         = (!mem_src && bcast && vlen_sel[1]) ? rc_embed : rc_global;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctl_q     <= '0;
            dest_q    <= '0;
            src2_q    <= '0;
            src3_q    <= '0;
            res_q     <= '0;
            pending_q <= '0;
            in_len_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctl_q     <= ctl_d;
                        dest_q    <= dest_in;
                        src2_q    <= src2_in;
                        src3_q    <= src3_in;
                        res_q     <= init_res;
                        pending_q <= active_d;
                        in_len_q  <= in_len_d;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (!any_pending)   state_q <= ST_IDLE;
                    else if (fma_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (res_valid) begin
                        res_q[idx*LW +: LW] <= res_data;
                        pending_q[idx]      <= 1'b0;
                        state_q             <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fma_valid = (state_q == ST_ISSUE) && any_pending;
    assign done      = (state_q == ST_ISSUE) && !any_pending;
    assign fma_rm    = ctl_q.rm;
    assign dest_out  = res_q;

    // ---------------- assertions ----------------
    logic [VW-1:0] len_keep;
    for (genvar j = 0; j < LANES; j++) begin : g_keep
        assign len_keep[j*LW +: LW] = {LW{in_len_q[j]}};
    end

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (fma_valid && !fma_ready) |=> (fma_valid && $stable(fma_a) && $stable(fma_b) && $stable(fma_c)))
        else $error("a_r8_hold_request");

    a_r8_single_lane: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant))
        else $error("a_r8_single_lane");

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("a_r9_done_one_cycle");

    a_r2_upper_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> ((dest_out & ~len_keep) == '0))
        else $error("a_r2_upper_clear");

    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start) |=> ($stable(ctl_q) && $stable(src3_q)))
        else $error("a_r10_busy_start");

endmodule

// File: tb/fmas_lane_seq_tb.sv
module fmas_lane_seq_tb_top;
    localparam int LW = 64;
    localparam int VW = 512;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
        logic [1:0]  rm;
    } iss_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, mask_en = 0, zero_mode = 0, mem_src = 0, bcast = 0;
    logic [1:0] form_sel = 0, vlen_sel = 0, rc_embed = 0, rc_global = 0;
    logic [7:0] mask_bits = 0;
    logic [VW-1:0] dest_in = 0, src2_in = 0, src3_in = 0;
    logic fma_ready = 0, res_valid = 0;
    logic [63:0] res_data = 0;
    logic fma_valid, done;
    logic [63:0] fma_a, fma_b, fma_c;
    logic [1:0] fma_rm;
    logic [VW-1:0] dest_out;

    int n_tests = 0;
    int n_fail  = 0;
    int stall_cycles = 0;
    string cur_tag = "R1";
    iss_t exp_q[$];

    always #2.5 clk = ~clk;

    fmas_lane_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .form_sel(form_sel), .vlen_sel(vlen_sel),
        .mask_en(mask_en), .mask_bits(mask_bits), .zero_mode(zero_mode),
        .mem_src(mem_src), .bcast(bcast), .rc_embed(rc_embed), .rc_global(rc_global),
        .dest_in(dest_in), .src2_in(src2_in), .src3_in(src3_in),
        .fma_valid(fma_valid), .fma_ready(fma_ready), .fma_a(fma_a), .fma_b(fma_b),
        .fma_c(fma_c), .fma_rm(fma_rm), .res_valid(res_valid), .res_data(res_data),
        .done(done), .dest_out(dest_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] fma_model(input logic [63:0] a, b, c);
        return (a ^ {b[31:0], b[63:32]}) + c;
    endfunction

    function automatic logic [63:0] lane_val(input int seed, input logic [7:0] k, input int j);
        return {k, 8'(j), 16'(seed), 32'(seed * 32'h9E37_79B9 + j * 32'h0101_0101)};
    endfunction

    // Responder / monitor: pops expected requests and checks them at handshake.
    initial begin
        forever begin
            @(negedge clk);
            res_valid = 1'b0;
            fma_ready = 1'b0;
            if (!rst && fma_valid) begin
                logic [63:0] a0;
                a0 = fma_a;
                for (int s = 0; s < stall_cycles; s++) begin
                    @(negedge clk);
                    chk(fma_valid && fma_a == a0, "R8 request held while stalled",
                        VW'(fma_a), VW'(a0));
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " R8 unexpected request"}, VW'(fma_a), '0);
                end else begin
                    iss_t e;
                    e = exp_q.pop_front();
                    chk(fma_a == e.a, {cur_tag, " R4 mul_a"}, VW'(fma_a), VW'(e.a));
                    chk(fma_b == e.b, {cur_tag, " R4/R6 mul_b"}, VW'(fma_b), VW'(e.b));
                    chk(fma_c == e.c, {cur_tag, " R3 addend"}, VW'(fma_c), VW'(e.c));
                    chk(fma_rm == e.rm, {cur_tag, " R7 rounding"}, VW'(fma_rm), VW'(e.rm));
                end
                fma_ready = 1'b1;
                res_data  = fma_model(fma_a, fma_b, fma_c);
                @(negedge clk);
                fma_ready = 1'b0;
                chk(!fma_valid, "R8 one lane outstanding", VW'(fma_valid), '0);
                res_valid = 1'b1;
            end
        end
    end

    task automatic run_op(input string tag, input logic [1:0] fm, input logic [1:0] vl,
                          input logic men, input logic [7:0] mb, input logic zm,
                          input logic ms, input logic bc, input logic [1:0] rce,
                          input logic [1:0] rcg, input int seed, input bit busy_start);
        logic [VW-1:0] d, s2, s3, expd;
        int kl;
        logic [1:0] rm;
        bit seen;
        cur_tag = tag;
        kl = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        rm = (!ms && bc && vl[1]) ? rce : rcg;
        for (int j = 0; j < 8; j++) begin
            d [j*64 +: 64] = lane_val(seed, 8'h11, j);
            s2[j*64 +: 64] = lane_val(seed, 8'hA2, j);
            s3[j*64 +: 64] = lane_val(seed, 8'h53 ^ 8'(j << 5), j);
        end
        expd = '0;
        for (int j = 0; j < 8; j++) begin
            logic [63:0] dl, s2l, s3l, a, b, c;
            dl = d[j*64 +: 64]; s2l = s2[j*64 +: 64];
            s3l = (ms && bc) ? s3[63:0] : s3[j*64 +: 64];
            if (j >= kl) expd[j*64 +: 64] = '0;
            else if (men && !mb[j]) expd[j*64 +: 64] = zm ? 64'd0 : dl;
            else begin
                case (fm)
                    2'd1:    begin a = s2l; b = dl;  c = s3l; end
                    2'd2:    begin a = s2l; b = s3l; c = dl;  end
                    default: begin a = dl;  b = s3l; c = s2l; end
                endcase
                if (j % 2 == 0) c[63] = ~c[63];
                exp_q.push_back('{a: a, b: b, c: c, rm: rm});
                expd[j*64 +: 64] = fma_model(a, b, c);
            end
        end
        @(negedge clk);
        form_sel = fm; vlen_sel = vl; mask_en = men; mask_bits = mb; zero_mode = zm;
        mem_src = ms; bcast = bc; rc_embed = rce; rc_global = rcg;
        dest_in = d; src2_in = s2; src3_in = s3;
        start = 1'b1;
        seen = 0;
        for (int t = 0; t < 400 && !seen; t++) begin
            @(negedge clk);
            start = 1'b0;
            if (busy_start && t == 0) begin
                start = 1'b1; form_sel = fm + 2'd1; vlen_sel = 2'd0;
                bcast = ~bc; dest_in = ~d; src2_in = ~s2; src3_in = ~s3;
            end
            if (done) seen = 1;
        end
        start = 1'b0;
        chk(seen, {tag, " R9 done seen"}, VW'(seen), VW'(1));
        chk(dest_out == expd, {tag, " R9/R5/R2 dest_out"}, dest_out, expd);
        chk(exp_q.size() == 0, {tag, " R8 all lanes issued"}, VW'(exp_q.size()), '0);
        exp_q.delete();
        @(negedge clk);
        chk(!done, {tag, " R9 done single cycle"}, VW'(done), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !fma_valid, "R1 reset outputs", VW'({done, fma_valid}), '0);
        chk(dest_out == '0, "R1 reset dest", dest_out, '0);

        stall_cycles = 0;
        run_op("R4 form132 len512",   2'd0, 2'd2, 0, 8'h00, 0, 0, 0, 2'd1, 2'd2, 5, 0);
        run_op("R5 form213 merge",    2'd1, 2'd1, 1, 8'h06, 0, 0, 0, 2'd0, 2'd3, 6, 0);
        run_op("R5 form231 zero len128", 2'd2, 2'd0, 1, 8'hFE, 1, 0, 0, 2'd0, 2'd1, 7, 0);
        run_op("R6 broadcast mem",    2'd1, 2'd2, 0, 8'h00, 0, 1, 1, 2'd3, 2'd1, 8, 0);
        run_op("R7 embedded rounding", 2'd0, 2'd2, 0, 8'h00, 0, 0, 1, 2'd3, 2'd1, 9, 0);
        run_op("R7 global at len256", 2'd2, 2'd1, 0, 8'h00, 0, 0, 1, 2'd3, 2'd2, 10, 0);
        run_op("R5 no active lanes",  2'd0, 2'd2, 1, 8'h00, 1, 0, 0, 2'd0, 2'd0, 11, 0);
        run_op("R2 spare codes",      2'd3, 2'd3, 1, 8'hA5, 0, 0, 0, 2'd2, 2'd1, 12, 0);
        stall_cycles = 2;
        run_op("R10 busy start",      2'd2, 2'd2, 1, 8'h3C, 1, 1, 1, 2'd1, 2'd3, 13, 1);
        run_op("R8 stalled ready",    2'd1, 2'd0, 0, 8'h00, 0, 0, 0, 2'd0, 2'd2, 14, 0);
        stall_cycles = 1;
        run_op("R3 odd only",         2'd0, 2'd2, 1, 8'hAA, 0, 1, 0, 2'd0, 2'd1, 15, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule